// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Empty/Near-Full Flag

This block is a 512-word, 18-bit first-in first-out buffer whose producer and consumer run on separate clocks. The clocks may be unrelated or the same. A word is stored on a load-clock rising edge while the load strobe enable is high. A word is removed on an unload-clock rising edge while the unload strobe enable is high. The buffer has first-word fall-through: the oldest stored word is always on the data output, with no unload edge needed to fetch it.

Four status outputs describe the fill level:
- an active-low full flag, computed on the load side;
- an active-low empty flag, computed on the unload side;
- a half-full flag;
- one combined flag that is high near either end of the range.

The two thresholds of the combined flag are a low offset X and a high offset Y. They are loaded from the low byte of the data input during a short window after reset. The window closes with the first stored word. If no programming happens, both thresholds are 64. A data-output enable stands in for a high-impedance output.

Top module: `dcfifo_flags`

## Requirements
- R1: The active-low full output `full_n` is 0 exactly when 512 words are held, and 1 at every lower count.
- R2: A load strobe while full leaves the held words and their order unchanged. After draining, exactly the 512 words held before the strobe come out, in load order.
- R3: An unload strobe while `empty_n` is 0 has no effect. A later stored word still appears on `dout`, and the count-based flags behave as for one held word.
- R4: `empty_n` is 0 while no word is held. The first word loaded into an empty buffer appears on `dout` and drives `empty_n` to 1 with no unload strobe. That word leaves only on a later unload strobe.
- R5: `half_full` is 1 exactly when 256 or more words are held.
- R6: `almost` is 1 when the count is at most X or at least 512−Y, and 0 for counts from X+1 to 511−Y.
- R7: While reset is low, and right after it is released, the outputs read `full_n`=1, `almost`=1, `half_full`=0 and `empty_n`=0.
- R8: After reset and before any word is stored, a load strobe with `prog_n`=0 copies `din[7:0]` into both X and Y. A second such strobe copies `din[7:0]` into Y only. A programming strobe stores no word.
- R9: If the first load strobe after reset has `prog_n`=1, X and Y stay at 64 and that strobe stores a word. Once a word has been stored, or two programming strobes have been made, `prog_n` is ignored and every non-full load strobe stores a word.
- R10: With unrelated load and unload clocks and interleaved strobes, words leave in exactly the order they were loaded, with no loss or duplication.
- R11: `dout_en` is the inverse of `oe_n`, and `oe_n` has no effect on the word shown on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Load clock |
| rclk | input | 1 | Unload clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe enable, sampled on `wclk` rising edge |
| prog_n | input | 1 | Active-low offset programming enable |
| din | input | 18 | Input word; bits 7:0 carry offsets while programming |
| ul_en | input | 1 | Unload strobe enable, sampled on `rclk` rising edge |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 18 | Oldest held word (first-word fall-through) |
| dout_en | output | 1 | High when the output would be driven |
| full_n | output | 1 | Low when 512 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 256 or more words |
| almost | output | 1 | High at or below X, or at or above 512−Y |

## Verification
The bench steps the fill level to each side of every threshold: X and X+1, 511−Y and 512−Y, 255 and 256, 511 and 512. It does this for the default offsets, for one-strobe programming and for two-strobe programming. An off-by-one compare or a wrong offset register would flip `almost` or `half_full` at one of these counts.

Strobes made into a full buffer and into an empty buffer are each followed by a drain or a fresh load. A design that moved a pointer on them would lose, repeat or misorder words, or would show a wrong count on the flags.

Programming strobes are checked not to leave a word in the buffer. A late `prog_n` low is checked not to block a store.

A long run with two unrelated clocks and random unload gaps compares every word against a queue. This catches crossing or fall-through staging errors that drop or duplicate words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Offset programming window state, load domain
  typedef enum logic [1:0] {
    PG_ARM  = 2'd0,   // just out of reset, nothing programmed or stored
    PG_ONE  = 2'd1,   // X and Y taken once, Y may be taken again
    PG_LOCK = 2'd2    // window closed
  } prog_state_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned OFFW    = 8,
  parameter int unsigned DEF_OFF = 64,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            prog_n,
  input  logic [OFFW-1:0] off_in,
  input  logic [PW-1:0]   rel_gray_s,
  output logic            wr_go,
  output logic [AW-1:0]   waddr,
  output logic [PW-1:0]   wgray,
  output logic            full_n,
  output logic            half_full,
  output logic            almost
);
  localparam logic [PW-1:0] CAP   = PW'(DEPTH);
  localparam logic [PW-1:0] HALF  = PW'(DEPTH / 2);
  localparam logic [OFFW-1:0] DEFV = OFFW'(DEF_OFF);

  prog_state_e     pst_q, pst_nxt;
  logic [PW-1:0]   wptr_q, wptr_nxt;
  logic [PW-1:0]   wgray_q, wgray_nxt;
  logic [OFFW-1:0] xoff_q, xoff_nxt;
  logic [OFFW-1:0] yoff_q, yoff_nxt;
  logic [PW-1:0]   rel_bin;
  logic [PW-1:0]   level;
  logic [PW-1:0]   x_ext;
  logic [PW-1:0]   hi_mark;
  logic            is_full;
  logic            prog_hit;

  // Gray to binary for the released-word pointer from the unload side
  always_comb begin
    for (int i = 0; i < PW; i++) rel_bin[i] = ^(rel_gray_s >> i);
  end

  assign level    = wptr_q - rel_bin;
  assign is_full  = (level == CAP);
  assign prog_hit = ld_en && !prog_n && (pst_q != PG_LOCK);
  assign wr_go    = ld_en && !is_full && !prog_hit;

  // Next-state logic
  always_comb begin
    pst_nxt  = pst_q;
    xoff_nxt = xoff_q;
    yoff_nxt = yoff_q;
    wptr_nxt = wptr_q;
    unique case (pst_q)
      PG_ARM: begin
        if (prog_hit) begin
          xoff_nxt = off_in;
          yoff_nxt = off_in;
          pst_nxt  = PG_ONE;
        end else if (ld_en) begin
          pst_nxt  = PG_LOCK;
        end
      end
      PG_ONE: begin
        if (prog_hit) yoff_nxt = off_in;
        if (ld_en)    pst_nxt  = PG_LOCK;
      end
      default: pst_nxt = PG_LOCK;
    endcase
    if (wr_go) wptr_nxt = wptr_q + PW'(1);
    wgray_nxt = wptr_nxt ^ (wptr_nxt >> 1);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_q   <= PG_ARM;
      wptr_q  <= '0;
      wgray_q <= '0;
      xoff_q  <= DEFV;
      yoff_q  <= DEFV;
    end else begin
      pst_q   <= pst_nxt;
      wptr_q  <= wptr_nxt;
      wgray_q <= wgray_nxt;
      xoff_q  <= xoff_nxt;
      yoff_q  <= yoff_nxt;
    end
  end

  assign x_ext     = PW'(xoff_q);
  assign hi_mark   = CAP - PW'(yoff_q);
  assign waddr     = wptr_q[AW-1:0];
  assign wgray     = wgray_q;
  assign full_n    = !is_full;
  assign half_full = (level >= HALF);
  assign almost    = (level <= x_ext) || (level >= hi_mark);

  // R1: the load-side level never exceeds capacity
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);
  // R2: a strobe into a full buffer does not move the write pointer
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !full_n) |=> $stable(wgray));
  // R8: a programming strobe stores nothing
  a_r8_prog_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !prog_n && pst_q != PG_LOCK) |=> $stable(wgray));
  // R5: a full buffer always reports half full and near full
  a_r5_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> (half_full && almost));
  // R10: the crossing pointer changes at most one bit per edge
  a_r10_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ul_en,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rel_gray,
  output logic [DW-1:0] dout,
  output logic          empty_n
);
  logic [PW-1:0] rptr_q, rptr_nxt;
  logic [PW-1:0] relp_q, relp_nxt;
  logic [PW-1:0] relg_q, relg_nxt;
  logic          ov_q, ov_nxt;
  logic [DW-1:0] dout_q, dout_nxt;
  logic [PW-1:0] rgray_cur;
  logic          mem_empty;
  logic          take;
  logic          fetch;

  assign rgray_cur = rptr_q ^ (rptr_q >> 1);
  assign mem_empty = (rgray_cur == wgray_s);
  assign take      = ul_en && ov_q;
  assign fetch     = !mem_empty && (!ov_q || take);

  // Next-state logic for the fall-through output stage
  always_comb begin
    rptr_nxt = rptr_q;
    relp_nxt = relp_q;
    ov_nxt   = ov_q;
    dout_nxt = dout_q;
    if (fetch) begin
      rptr_nxt = rptr_q + PW'(1);
      dout_nxt = rdata;
      ov_nxt   = 1'b1;
    end else if (take) begin
      ov_nxt   = 1'b0;
    end
    if (take) relp_nxt = relp_q + PW'(1);
    relg_nxt = relp_nxt ^ (relp_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      relp_q <= '0;
      relg_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      rptr_q <= rptr_nxt;
      relp_q <= relp_nxt;
      relg_q <= relg_nxt;
      ov_q   <= ov_nxt;
    end
  end

  // Data stage is not reset
  always_ff @(posedge clk) begin
    if (fetch) dout_q <= dout_nxt;
  end

  assign raddr    = rptr_q[AW-1:0];
  assign rel_gray = relg_q;
  assign dout     = dout_q;
  assign empty_n  = ov_q;

  // R3: an unload strobe while empty releases nothing
  a_r3_empty_unload_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_en && !empty_n) |=> $stable(rel_gray));
  // R4: a presented word stays until it is unloaded
  a_r4_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && !ul_en) |=> (empty_n && $stable(dout)));
  // R10: the released pointer changes at most one bit per edge
  a_r10_relgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_gray ^ $past(rel_gray)));
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned DW      = 18,
  parameter int unsigned OFFW    = 8,
  parameter int unsigned DEF_OFF = 64,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          prog_n,
  input  logic [DW-1:0] din,
  input  logic          ul_en,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost
);
  logic          wrst_n, rrst_n;
  logic          wr_go;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, wgray_s;
  logic [PW-1:0] rel_gray, rel_gray_s;
  logic [DW-1:0] rdata;
  logic [DW-1:0] mem [DEPTH];

  dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_wr_ctl #(.DEPTH(DEPTH), .OFFW(OFFW), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .ld_en(ld_en), .prog_n(prog_n),
    .off_in(din[OFFW-1:0]), .rel_gray_s(rel_gray_s), .wr_go(wr_go),
    .waddr(waddr), .wgray(wgray), .full_n(full_n),
    .half_full(half_full), .almost(almost)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray),    .q(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rel_gray), .q(rel_gray_s));

  dcf_rd_ctl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .ul_en(ul_en), .wgray_s(wgray_s),
    .rdata(rdata), .raddr(raddr), .rel_gray(rel_gray),
    .dout(dout), .empty_n(empty_n)
  );

  // Storage array, written on the load side only
  always_ff @(posedge wclk) begin
    if (wr_go) mem[waddr] <= din;
  end

  assign rdata   = mem[raddr];
  assign dout_en = !oe_n;
endmodule

// File: tb/dcfifo_flags_bench.sv
`timescale 1ns/1ps
module dcfifo_flags_bench;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        rst_n, ld_en, prog_n, ul_en, oe_n;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_en, full_n, empty_n, half_full, almost;

  always #2   wclk = ~wclk;   // 250 MHz load clock
  always #3.3 rclk = ~rclk;   // unrelated unload clock

  dcfifo_flags u_dcfifo_flags (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ld_en(ld_en), .prog_n(prog_n),
    .din(din), .ul_en(ul_en), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
    .full_n(full_n), .empty_n(empty_n), .half_full(half_full), .almost(almost)
  );

  int          checks = 0, errors = 0;
  int          cnt = 0, seq = 0, rd_pct = 100;
  bit          rd_run = 0, manual = 0, done = 0;
  logic [17:0] sbq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic flags(input string req, input int efull, input int ehf,
                       input int ealm, input int eempty);
    chk(full_n == efull[0],    req, $sformatf("full_n at %0d", cnt),    full_n, efull);
    chk(half_full == ehf[0],   req, $sformatf("half_full at %0d", cnt), half_full, ehf);
    chk(almost == ealm[0],     req, $sformatf("almost at %0d", cnt),    almost, ealm);
    chk(empty_n == eempty[0],  req, $sformatf("empty_n at %0d", cnt),   empty_n, eempty);
  endtask

  // Driver: one load strobe; stored words go to the scoreboard
  task automatic load(input logic [17:0] d, input bit pn, input bit store);
    @(negedge wclk);
    din = d; prog_n = pn; ld_en = 1'b1;
    @(negedge wclk);
    ld_en = 1'b0; prog_n = 1'b1;
    if (store) begin
      sbq.push_back(d);
      cnt++;
    end
  endtask

  task automatic put_word(input bit pn);
    load(18'(seq * 7 + 18'h155), pn, 1'b1);
    seq++;
  endtask

  task automatic fill_to(input int n);
    while (cnt < n) put_word(1'b1);
    settle();
  endtask

  task automatic drain();
    rd_pct = 100;
    rd_run = 1'b1;
    wait (sbq.size() == 0);
    rd_run = 1'b0;
    settle();
  endtask

  task automatic pulse_ul(input int n);
    manual = 1'b1;
    @(negedge rclk) ul_en = 1'b1;
    repeat (n) @(negedge rclk);
    ul_en = 1'b0;
    manual = 1'b0;
  endtask

  task automatic do_reset();
    rd_run = 1'b0; manual = 1'b0; ul_en = 1'b0; ld_en = 1'b0; prog_n = 1'b1;
    rst_n = 1'b0;
    sbq.delete();
    cnt = 0;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    flags("R7", 1, 0, 1, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    flags("R7", 1, 0, 1, 0);
  endtask

  // Monitor: pops and compares each word as it is unloaded
  always @(negedge rclk) begin
    if (rd_run) begin
      if (empty_n === 1'b1 && $urandom_range(99) < rd_pct) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R10", "word with empty scoreboard", dout, 0);
        end else begin
          logic [17:0] e;
          e = sbq.pop_front();
          chk(dout == e, "R10", "unloaded word", dout, e);
          cnt--;
        end
        ul_en = 1'b1;
      end else begin
        ul_en = 1'b0;
      end
    end else if (!manual) begin
      ul_en = 1'b0;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ul_en = 1'b0; prog_n = 1'b1; oe_n = 1'b0; din = '0;

    // Default offsets X = Y = 64
    do_reset();
    put_word(1'b1);
    settle();
    chk(empty_n == 1'b1, "R4", "fall-through empty_n", empty_n, 1);
    chk(dout == sbq[0], "R4", "fall-through word", dout, sbq[0]);
    oe_n = 1'b1; #1;
    chk(dout_en == 1'b0, "R11", "dout_en with oe_n high", dout_en, 0);
    chk(dout == sbq[0], "R11", "word with oe_n high", dout, sbq[0]);
    oe_n = 1'b0; #1;
    chk(dout_en == 1'b1, "R11", "dout_en with oe_n low", dout_en, 1);
    fill_to(64);  flags("R9", 1, 0, 1, 1);
    fill_to(65);  flags("R6", 1, 0, 0, 1);
    fill_to(99);
    put_word(1'b0);   // R9: late prog_n low still stores
    fill_to(255); flags("R5", 1, 0, 0, 1);
    fill_to(256); flags("R5", 1, 1, 0, 1);
    fill_to(447); flags("R9", 1, 1, 0, 1);
    fill_to(448); flags("R9", 1, 1, 1, 1);
    fill_to(511); flags("R1", 1, 1, 1, 1);
    fill_to(512); flags("R1", 0, 1, 1, 1);
    for (int i = 0; i < 3; i++) load(18'h3FFFF - 18'(i), 1'b1, 1'b0);
    settle();
    flags("R2", 0, 1, 1, 1);
    drain();
    flags("R2", 1, 0, 1, 0);
    pulse_ul(5);      // R3: unload strobes while empty
    settle();
    put_word(1'b1);
    settle();
    chk(dout == sbq[0], "R3", "word after empty unloads", dout, sbq[0]);
    flags("R3", 1, 0, 1, 1);
    pulse_ul(1);
    settle();
    void'(sbq.pop_front());
    cnt--;
    flags("R4", 1, 0, 1, 0);

    // One programming strobe: X = Y = 10
    do_reset();
    load(18'h0000A, 1'b0, 1'b0);
    put_word(1'b1);
    settle();
    chk(dout == sbq[0], "R8", "first stored word after programming", dout, sbq[0]);
    fill_to(10);  flags("R8", 1, 0, 1, 1);
    fill_to(11);  flags("R8", 1, 0, 0, 1);
    fill_to(501); flags("R6", 1, 1, 0, 1);
    fill_to(502); flags("R6", 1, 1, 1, 1);
    drain();

    // Two programming strobes: X = 5, Y = 20
    do_reset();
    load(18'h3FF05, 1'b0, 1'b0);
    load(18'h00014, 1'b0, 1'b0);
    put_word(1'b1);
    settle();
    chk(dout == sbq[0], "R8", "first word after two strobes", dout, sbq[0]);
    fill_to(5);   flags("R8", 1, 0, 1, 1);
    fill_to(6);   flags("R8", 1, 0, 0, 1);
    fill_to(491); flags("R6", 1, 1, 0, 1);
    fill_to(492); flags("R6", 1, 1, 1, 1);
    drain();

    // Streaming with unrelated clocks and random gaps
    do_reset();
    rd_pct = 50;
    rd_run = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      while (cnt >= 500) @(negedge wclk);
      put_word(1'b1);
      repeat ($urandom_range(2)) @(negedge wclk);
    end
    drain();
    chk(sbq.size() == 0, "R10", "scoreboard empty after stream", sbq.size(), 0);
    flags("R10", 1, 0, 1, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule